// File: doc/BRIEF.md
# NiMH Charge Phase Controller

This block sequences the charge cycle of one or more nickel-metal-hydride cells. Each cell has its own phase machine. It moves through power-on reset, a pack qualification wait, a reduced-rate precharge, a short unloaded cell test, full-rate charging, a reduced-rate top-off, indefinite trickle maintenance, and a sticky fault phase. Analog comparators outside the block supply per-cell threshold flags: cell voltage low, high-open-circuit and over-limit; temperature cold, warm and hot. They also supply an impedance-test failure flag and a termination request from a negative-slope or flat-voltage detector. A slow tick of roughly one second clocks every phase decision.

The phase timers count ticks. The precharge limit and the cell-test interval are parameters. The full-rate limit arrives as a tick count on a port, and top-off uses half of it. Undervoltage lockout or suspend sends every machine back to reset and clears every timer. A series/parallel input decides whether a fault in one cell stops all cells or only that cell.

For each cell the block reports the phase, a two-bit status for an indicator driver and a two-bit charge-rate select for the pulse generator.

Top module: `nimh_charge_ctrl`

## Requirements
- R1: When `uvlo` or `suspend` is high at a clock edge, every cell's phase becomes RESET (code 0) at that edge, without waiting for a tick. One clock after both are low, the phase is PRESENCE (code 1). A synchronous `rst` also gives RESET.
- R2: In PRESENCE, phase changes only on a tick. A tick with `v_max2`, `t_cold` or `t_warm` set goes to FAULT (code 7). Otherwise, a tick with `v_max1` clear goes to PRECHG (code 2), and with `v_max1` set the phase stays. In any phase other than RESET, the phase is stable on cycles without a tick, unless a hold or a forced fault occurs.
- R3: In PRECHG, a tick with `v_low` set keeps precharging. A tick with `v_low` clear, `t_warm` clear and no fault condition goes to CELLTEST (code 3).
- R4: In PRECHG, a tick with `v_max2`, `t_cold` or `t_hot` set goes to FAULT. PRECHG also goes to FAULT on its PCHG_TICKS-th tick if the cell has not qualified. If the cell qualifies on that same tick, it goes to CELLTEST instead.
- R5: CELLTEST lasts one tick. On that tick, `ctest_fail` gives FAULT and a pass gives FAST (code 4). FAST enters CELLTEST on every CTST_TICKS-th consecutive tick spent in FAST.
- R6: In FAST or TOPOFF (code 5), a tick with `v_max2` set goes to FAULT, ahead of any other exit.
- R7: In FAST, tick exits are taken in this order: `t_hot` goes to MAINT (code 6). Then `term_req`, or reaching `fast_limit` ticks counted from the tick that left PRECHG, goes to TOPOFF. Then the periodic cell test.
- R8: TOPOFF goes to MAINT on a tick with `t_hot`, or on its (`fast_limit`>>1)-th tick. MAINT is held until reset, hold or a forced fault.
- R9: FAULT is left only through reset or hold. With `par_mode`=0 (series), a fault in any cell forces every other cell to FAULT one clock later. With `par_mode`=1 (parallel), the cells are independent.
- R10: Status per cell is 0 in RESET and PRESENCE (empty), 1 in PRECHG, CELLTEST, FAST and TOPOFF (charging), 2 in MAINT and 3 in FAULT. Rate per cell is 0 (off) in RESET, PRESENCE, CELLTEST and FAULT, 1 (reduced) in PRECHG and TOPOFF, 2 (full) in FAST and 3 (trickle) in MAINT. Cell n occupies bits [3n+2:3n] of `phase_o` and [2n+1:2n] of `status_o` and `rate_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle slow timebase pulse |
| uvlo | input | 1 | Supply undervoltage lockout |
| suspend | input | 1 | Suspend request |
| par_mode | input | 1 | 1 = parallel cells, 0 = series |
| fast_limit | input | TW | Full-rate time-out in ticks |
| v_low | input | NC | Cell below the precharge threshold |
| v_max1 | input | NC | Open-circuit cell above the start limit |
| v_max2 | input | NC | Cell above the absolute limit |
| t_cold | input | NC | Temperature below the low limit |
| t_warm | input | NC | Temperature above the start limit |
| t_hot | input | NC | Temperature above the stop limit |
| ctest_fail | input | NC | Loaded-minus-unloaded voltage above the test threshold |
| term_req | input | NC | Slope or flat-voltage termination request |
| phase_o | output | 3*NC | Phase code per cell |
| status_o | output | 2*NC | Indicator status per cell |
| rate_o | output | 2*NC | Charge-rate select per cell |

## Verification
The bench targets several corner cases:
- Precharge time-out on its last tick, against a cell that qualifies on that same tick. A design with the order swapped would fault a good cell.
- Over-voltage arriving together with over-temperature in full-rate charge. This must give a fault, not maintenance.
- Top-off expiring on exactly half the full-rate limit. An off-by-one error would show one tick early or late.
- The periodic cell test, which must land on the interval boundary.
- Series-mode fault propagation to the sister cell, against parallel-mode independence.

Long random runs are compared cycle by cycle with a tick-level reference model. These runs catch timers that fail to clear or keep counting across phases.

// File: rtl/nimh_pkg.sv
package nimh_pkg;

    typedef enum logic [2:0] {
        PH_RESET    = 3'd0,
        PH_PRESENCE = 3'd1,
        PH_PRECHG   = 3'd2,
        PH_CELLTEST = 3'd3,
        PH_FAST     = 3'd4,
        PH_TOPOFF   = 3'd5,
        PH_MAINT    = 3'd6,
        PH_FAULT    = 3'd7
    } phase_e;

    typedef enum logic [1:0] {
        ST_EMPTY    = 2'd0,
        ST_CHARGING = 2'd1,
        ST_MAINT    = 2'd2,
        ST_FAULT    = 2'd3
    } status_e;

    typedef enum logic [1:0] {
        RT_OFF     = 2'd0,
        RT_REDUCED = 2'd1,
        RT_FULL    = 2'd2,
        RT_TRICKLE = 2'd3
    } rate_e;

    // comparator and detector flags for one cell
    typedef struct packed {
        logic v_low;
        logic v_max1;
        logic v_max2;
        logic t_cold;
        logic t_warm;
        logic t_hot;
        logic ctest_fail;
        logic term_req;
    } cell_flags_t;

    // phases in which the charge timer advances
    function automatic logic timed_phase(phase_e p);
        return (p == PH_PRECHG) || (p == PH_CELLTEST) ||
               (p == PH_FAST)   || (p == PH_TOPOFF);
    endfunction

    function automatic status_e status_of(phase_e p);
        case (p)
            PH_RESET, PH_PRESENCE: return ST_EMPTY;
            PH_MAINT:              return ST_MAINT;
            PH_FAULT:              return ST_FAULT;
            default:               return ST_CHARGING;
        endcase
    endfunction

    function automatic rate_e rate_of(phase_e p);
        case (p)
            PH_PRECHG, PH_TOPOFF: return RT_REDUCED;
            PH_FAST:              return RT_FULL;
            PH_MAINT:             return RT_TRICKLE;
            default:              return RT_OFF;
        endcase
    endfunction

endpackage

// File: rtl/nimh_tick_counter.sv
module nimh_tick_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/nimh_cell_fsm.sv
module nimh_cell_fsm
    import nimh_pkg::*;
#(
    parameter int TW         = 16,
    parameter int PCHG_TICKS = 2040,
    parameter int CTST_TICKS = 31
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          tick,
    input  logic          force_fault,
    input  cell_flags_t   fl,
    input  logic [TW-1:0] fast_limit,
    output phase_e        phase
);
    localparam int            CW       = $clog2(CTST_TICKS + 1);
    localparam logic [TW:0]   PCHG_LIM = (TW+1)'(PCHG_TICKS);
    localparam logic [CW-1:0] CT_LAST  = CW'(CTST_TICKS - 1);

    phase_e        nxt;
    logic [TW-1:0] chg_cnt;
    logic [CW-1:0] ct_cnt;
    logic [TW:0]   chg_after;
    logic          pchg_exp, fast_exp, top_exp, ct_due;
    logic          chg_clr, chg_inc, ct_clr;

    // expiry tests look at the count this tick would reach
    assign chg_after = {1'b0, chg_cnt} + 1'b1;
    assign pchg_exp  = chg_after >= PCHG_LIM;
    assign fast_exp  = chg_after >= {1'b0, fast_limit};
    assign top_exp   = chg_after >= {2'b00, fast_limit[TW-1:1]};
    assign ct_due    = ct_cnt == CT_LAST;

    always_comb begin
        nxt = phase;
        if (hold) begin
            nxt = PH_RESET;
        end else if (force_fault && phase != PH_RESET) begin
            nxt = PH_FAULT;
        end else begin
            case (phase)
                PH_RESET: nxt = PH_PRESENCE;
                PH_PRESENCE: if (tick) begin
                    if (fl.v_max2 || fl.t_cold || fl.t_warm) nxt = PH_FAULT;
                    else if (!fl.v_max1)                     nxt = PH_PRECHG;
                end
                PH_PRECHG: if (tick) begin
                    if (fl.v_max2 || fl.t_cold || fl.t_hot) nxt = PH_FAULT;
                    else if (!fl.v_low && !fl.t_warm)       nxt = PH_CELLTEST;
                    else if (pchg_exp)                      nxt = PH_FAULT;
                end
                PH_CELLTEST: if (tick) begin
                    nxt = fl.ctest_fail ? PH_FAULT : PH_FAST;
                end
                PH_FAST: if (tick) begin
                    if (fl.v_max2)                    nxt = PH_FAULT;
                    else if (fl.t_hot)                nxt = PH_MAINT;
                    else if (fl.term_req || fast_exp) nxt = PH_TOPOFF;
                    else if (ct_due)                  nxt = PH_CELLTEST;
                end
                PH_TOPOFF: if (tick) begin
                    if (fl.v_max2)               nxt = PH_FAULT;
                    else if (fl.t_hot || top_exp) nxt = PH_MAINT;
                end
                default: nxt = phase;
            endcase
        end
    end

    // charge timer restarts entering precharge or top-off and on leaving precharge;
    // it keeps running across the periodic cell test inside full-rate charge
    assign chg_clr = hold || ((nxt != phase) &&
                     (nxt == PH_PRECHG || nxt == PH_TOPOFF || phase == PH_PRECHG));
    assign chg_inc = tick && timed_phase(phase);
    assign ct_clr  = hold || !(phase == PH_FAST && nxt == PH_FAST);

    nimh_tick_counter #(.W(TW)) u_chg_timer (
        .clk(clk), .rst(rst), .clr(chg_clr), .inc(chg_inc), .cnt(chg_cnt)
    );

    nimh_tick_counter #(.W(CW)) u_test_timer (
        .clk(clk), .rst(rst), .clr(ct_clr), .inc(tick), .cnt(ct_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_RESET;
        else     phase <= nxt;
    end

    p_hold_reset_r1: assert property (@(posedge clk) disable iff (rst)
        hold |=> (phase == PH_RESET));

    p_leave_reset_r1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RESET && !hold) |=> (phase == PH_PRESENCE));

    p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !hold && !force_fault && phase != PH_RESET) |=> $stable(phase));

    p_ctest_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !hold && !force_fault && phase == PH_CELLTEST && !fl.ctest_fail)
        |=> (phase == PH_FAST));

    p_vmax_fault_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && !hold && fl.v_max2 && (phase == PH_FAST || phase == PH_TOPOFF))
        |=> (phase == PH_FAULT));

    p_maint_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MAINT && !hold && !force_fault) |=> (phase == PH_MAINT));

    p_fault_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FAULT && !hold) |=> (phase == PH_FAULT));
endmodule

// File: rtl/nimh_out_map.sv
module nimh_out_map
    import nimh_pkg::*;
(
    input  phase_e  phase,
    output status_e status,
    output rate_e   rate
);
    // R10: indicator status and rate select derived from the phase
    always_comb begin
        status = status_of(phase);
        rate   = rate_of(phase);
    end
endmodule

// File: rtl/nimh_charge_ctrl.sv
module nimh_charge_ctrl
    import nimh_pkg::*;
#(
    parameter int NC         = 2,
    parameter int TW         = 16,
    parameter int PCHG_TICKS = 2040,
    parameter int CTST_TICKS = 31
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            uvlo,
    input  logic            suspend,
    input  logic            par_mode,
    input  logic [TW-1:0]   fast_limit,
    input  logic [NC-1:0]   v_low,
    input  logic [NC-1:0]   v_max1,
    input  logic [NC-1:0]   v_max2,
    input  logic [NC-1:0]   t_cold,
    input  logic [NC-1:0]   t_warm,
    input  logic [NC-1:0]   t_hot,
    input  logic [NC-1:0]   ctest_fail,
    input  logic [NC-1:0]   term_req,
    output logic [3*NC-1:0] phase_o,
    output logic [2*NC-1:0] status_o,
    output logic [2*NC-1:0] rate_o
);
    logic   hold;
    logic   any_fault, all_fault, force_fault;
    phase_e ph [NC];

    assign hold = uvlo | suspend;

    always_comb begin
        any_fault = 1'b0;
        all_fault = 1'b1;
        for (int c = 0; c < NC; c++) begin
            any_fault = any_fault | (ph[c] == PH_FAULT);
            all_fault = all_fault & (ph[c] == PH_FAULT);
        end
    end

    // series stack: one bad cell stops the whole string
    assign force_fault = !par_mode && any_fault;

    for (genvar g = 0; g < NC; g++) begin : g_cell
        cell_flags_t fl;
        status_e     st;
        rate_e       rt;

        assign fl = '{v_low: v_low[g], v_max1: v_max1[g], v_max2: v_max2[g],
                      t_cold: t_cold[g], t_warm: t_warm[g], t_hot: t_hot[g],
                      ctest_fail: ctest_fail[g], term_req: term_req[g]};

        nimh_cell_fsm #(
            .TW(TW), .PCHG_TICKS(PCHG_TICKS), .CTST_TICKS(CTST_TICKS)
        ) u_fsm (
            .clk(clk), .rst(rst), .hold(hold), .tick(tick),
            .force_fault(force_fault), .fl(fl), .fast_limit(fast_limit),
            .phase(ph[g])
        );

        nimh_out_map u_map (.phase(ph[g]), .status(st), .rate(rt));

        assign phase_o[3*g +: 3]  = ph[g];
        assign status_o[2*g +: 2] = st;
        assign rate_o[2*g +: 2]   = rt;
    end

    p_series_fault_r9: assert property (@(posedge clk) disable iff (rst)
        (!par_mode && any_fault && !hold) |=> all_fault);
endmodule

// File: tb/test_nimh_charge_ctrl.sv
module test_nimh_charge_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NC   = 2;
    localparam int TW   = 16;
    localparam int PCHG = 40;
    localparam int CTST = 8;

    localparam int P_RST = 0, P_PRES = 1, P_PRE = 2, P_CT = 3,
                   P_FAST = 4, P_TOP = 5, P_MNT = 6, P_FLT = 7;

    logic clk = 1'b0;
    logic rst = 1'b1, tick = 1'b0, uvlo = 1'b0, suspend = 1'b0, par_mode = 1'b1;
    logic [TW-1:0] fast_limit = 16'd30;
    logic [NC-1:0] v_low = '0, v_max1 = '1, v_max2 = '0, t_cold = '0, t_warm = '0,
                   t_hot = '0, ctest_fail = '0, term_req = '0;
    logic [3*NC-1:0] phase_o;
    logic [2*NC-1:0] status_o, rate_o;

    int checks = 0, fails = 0;
    int m_ph [NC], m_chg [NC], m_ct [NC];
    int n_ph [NC], n_chg [NC], n_ct [NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    nimh_charge_ctrl #(.NC(NC), .TW(TW), .PCHG_TICKS(PCHG), .CTST_TICKS(CTST)) i_nimh_charge_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .uvlo(uvlo), .suspend(suspend),
        .par_mode(par_mode), .fast_limit(fast_limit), .v_low(v_low), .v_max1(v_max1),
        .v_max2(v_max2), .t_cold(t_cold), .t_warm(t_warm), .t_hot(t_hot),
        .ctest_fail(ctest_fail), .term_req(term_req),
        .phase_o(phase_o), .status_o(status_o), .rate_o(rate_o)
    );

    function automatic int exp_status(int p);
        if (p <= P_PRES) return 0;
        if (p == P_MNT)  return 2;
        if (p == P_FLT)  return 3;
        return 1;
    endfunction

    function automatic int exp_rate(int p);
        if (p == P_PRE || p == P_TOP) return 1;
        if (p == P_FAST) return 2;
        if (p == P_MNT)  return 3;
        return 0;
    endfunction

    function automatic string tag_of(int p);
        case (p)
            P_RST:  return "R1";
            P_PRES: return "R2";
            P_PRE:  return "R3";
            P_CT:   return "R5";
            P_FAST: return "R7";
            P_TOP, P_MNT: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(int act, int exp, string tag, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // reference model: next phase and timers from the requirements
    task automatic model_step();
        bit hold = uvlo || suspend;
        bit ff = 0;
        for (int c = 0; c < NC; c++) if (m_ph[c] == P_FLT) ff = 1;
        ff = ff && !par_mode;
        for (int c = 0; c < NC; c++) begin
            int p = m_ph[c];
            int np = p;
            int after = m_chg[c] + 1;
            if (rst || hold) np = P_RST;
            else if (ff && p != P_RST) np = P_FLT;
            else case (p)
                P_RST: np = P_PRES;
                P_PRES: if (tick) begin
                    if (v_max2[c] || t_cold[c] || t_warm[c]) np = P_FLT;
                    else if (!v_max1[c]) np = P_PRE;
                end
                P_PRE: if (tick) begin
                    if (v_max2[c] || t_cold[c] || t_hot[c]) np = P_FLT;
                    else if (!v_low[c] && !t_warm[c]) np = P_CT;
                    else if (after >= PCHG) np = P_FLT;
                end
                P_CT: if (tick) np = ctest_fail[c] ? P_FLT : P_FAST;
                P_FAST: if (tick) begin
                    if (v_max2[c]) np = P_FLT;
                    else if (t_hot[c]) np = P_MNT;
                    else if (term_req[c] || after >= int'(fast_limit)) np = P_TOP;
                    else if (m_ct[c] == CTST - 1) np = P_CT;
                end
                P_TOP: if (tick) begin
                    if (v_max2[c]) np = P_FLT;
                    else if (t_hot[c] || after >= int'(fast_limit >> 1)) np = P_MNT;
                end
                default: np = p;
            endcase
            n_ph[c] = np;
            if (rst || hold || (np != p && (np == P_PRE || np == P_TOP || p == P_PRE)))
                n_chg[c] = 0;
            else if (tick && p >= P_PRE && p <= P_TOP && m_chg[c] < 65535)
                n_chg[c] = m_chg[c] + 1;
            else
                n_chg[c] = m_chg[c];
            if (rst || hold || !(p == P_FAST && np == P_FAST)) n_ct[c] = 0;
            else n_ct[c] = m_ct[c] + (tick ? 1 : 0);
        end
    endtask

    task automatic run_cycle();
        model_step();
        @(posedge clk);
        #1;
        for (int c = 0; c < NC; c++) begin
            m_ph[c] = n_ph[c]; m_chg[c] = n_chg[c]; m_ct[c] = n_ct[c];
            chk(int'(phase_o[3*c +: 3]), m_ph[c], tag_of(m_ph[c]), "model phase");
            chk(int'(status_o[2*c +: 2]), exp_status(m_ph[c]), "R10", "status");
            chk(int'(rate_o[2*c +: 2]), exp_rate(m_ph[c]), "R10", "rate");
        end
    endtask

    task automatic tickn(int n);
        tick = 1'b1;
        repeat (n) run_cycle();
        tick = 1'b0;
    endtask

    task automatic expect_ph(int c, int exp, string tag);
        chk(int'(phase_o[3*c +: 3]), exp, tag, "phase");
    endtask

    task automatic rehold();
        uvlo = 1'b1; run_cycle(); uvlo = 1'b0; run_cycle();
    endtask

    task automatic to_fast();
        v_max1[0] = 1'b0; v_low[0] = 1'b1; tickn(1);
        v_low[0] = 1'b0; tickn(2);
    endtask

    task automatic pulse_rst();
        rst = 1'b1; run_cycle(); rst = 1'b0; run_cycle();
    endtask

    initial begin
        void'($urandom(32'h5eed1234));
        for (int c = 0; c < NC; c++) begin m_ph[c] = 0; m_chg[c] = 0; m_ct[c] = 0; end

        // R1 reset state and release
        run_cycle(); rst = 1'b0;
        expect_ph(0, P_RST, "R1");
        chk(int'(status_o), 0, "R10", "status after reset");
        chk(int'(rate_o), 0, "R10", "rate after reset");
        run_cycle(); expect_ph(0, P_PRES, "R1");

        // R2 presence waits for a low open-circuit voltage
        tickn(3); expect_ph(0, P_PRES, "R2");
        v_max1[0] = 1'b0; v_low[0] = 1'b1; tickn(1); expect_ph(0, P_PRE, "R2");
        chk(int'(rate_o[1:0]), 1, "R10", "precharge rate");
        tickn(5); expect_ph(0, P_PRE, "R3");
        v_low[0] = 1'b0; t_warm[0] = 1'b1; tickn(1); expect_ph(0, P_PRE, "R3");
        t_warm[0] = 1'b0; tickn(1); expect_ph(0, P_CT, "R3");
        chk(int'(rate_o[1:0]), 0, "R5", "cell test rate");
        tickn(1); expect_ph(0, P_FAST, "R5");
        chk(int'(rate_o[1:0]), 2, "R10", "fast rate");
        tickn(CTST - 1); expect_ph(0, P_FAST, "R5");
        tickn(1); expect_ph(0, P_CT, "R5");
        ctest_fail[0] = 1'b1; tickn(1); expect_ph(0, P_FLT, "R5");
        ctest_fail[0] = 1'b0;
        chk(int'(status_o[1:0]), 3, "R10", "fault status");
        tickn(5); expect_ph(0, P_FLT, "R9");

        // R1 suspend
        suspend = 1'b1; run_cycle(); expect_ph(0, P_RST, "R1");
        suspend = 1'b0; run_cycle(); expect_ph(0, P_PRES, "R1");

        // R2 cold pack faults at qualification
        t_cold[0] = 1'b1; tickn(1); expect_ph(0, P_FLT, "R2");
        t_cold[0] = 1'b0; rehold();

        // R4 precharge time-out
        v_low[0] = 1'b1; tickn(1); expect_ph(0, P_PRE, "R4");
        tickn(PCHG - 1); expect_ph(0, P_PRE, "R4");
        tickn(1); expect_ph(0, P_FLT, "R4");
        rehold();
        // R4 qualification wins on the last tick
        tickn(1); tickn(PCHG - 1); expect_ph(0, P_PRE, "R4");
        v_low[0] = 1'b0; tickn(1); expect_ph(0, P_CT, "R4");
        // R4 hot precharge
        rehold(); v_low[0] = 1'b1; tickn(1);
        t_hot[0] = 1'b1; tickn(1); expect_ph(0, P_FLT, "R4");
        t_hot[0] = 1'b0; rehold();

        // R7 termination request, R8 top-off length
        to_fast(); expect_ph(0, P_FAST, "R7");
        term_req[0] = 1'b1; tickn(1); expect_ph(0, P_TOP, "R7");
        term_req[0] = 1'b0;
        tickn(14); expect_ph(0, P_TOP, "R8");
        tickn(1); expect_ph(0, P_MNT, "R8");
        tickn(20); expect_ph(0, P_MNT, "R8");
        chk(int'(status_o[1:0]), 2, "R10", "maint status");
        chk(int'(rate_o[1:0]), 3, "R10", "maint rate");
        rehold();

        // R7 hot in fast goes to maintenance
        to_fast(); t_hot[0] = 1'b1; tickn(1); expect_ph(0, P_MNT, "R7");
        t_hot[0] = 1'b0; rehold();

        // R6 over-voltage beats over-temperature
        to_fast(); v_max2[0] = 1'b1; t_hot[0] = 1'b1; tickn(1); expect_ph(0, P_FLT, "R6");
        v_max2[0] = 1'b0; t_hot[0] = 1'b0; rehold();

        // R7 fast timer then top-off timer
        to_fast(); tickn(60); expect_ph(0, P_MNT, "R7");
        rehold();

        // R6 over-voltage in top-off
        to_fast(); term_req[0] = 1'b1; tickn(1); term_req[0] = 1'b0;
        v_max2[0] = 1'b1; tickn(1); expect_ph(0, P_FLT, "R6");
        v_max2[0] = 1'b0; v_max1[0] = 1'b1; rehold();

        // R9 series propagation
        par_mode = 1'b0; pulse_rst();
        v_max1 = '0; v_low = '1; tickn(1);
        v_max2[1] = 1'b1; tickn(1);
        expect_ph(1, P_FLT, "R9"); expect_ph(0, P_PRE, "R9");
        v_max2[1] = 1'b0; run_cycle(); expect_ph(0, P_FLT, "R9");
        // R9 parallel independence
        par_mode = 1'b1; pulse_rst();
        tickn(1); v_max2[1] = 1'b1; tickn(1); v_max2[1] = 1'b0;
        run_cycle(); run_cycle();
        expect_ph(1, P_FLT, "R9"); expect_ph(0, P_PRE, "R9");
        v_max1 = '1; v_low = '0;

        // random episodes against the reference model
        for (int ep = 0; ep < 20; ep++) begin
            par_mode = 1'($urandom % 2);
            fast_limit = 16'(4 + $urandom % 40);
            pulse_rst();
            for (int k = 0; k < 1500; k++) begin
                tick    = 1'($urandom % 2);
                uvlo    = ($urandom % 700) == 0;
                suspend = ($urandom % 900) == 0;
                for (int c = 0; c < NC; c++) begin
                    v_low[c]      = ($urandom % 4) == 0;
                    v_max1[c]     = ($urandom % 4) == 0;
                    v_max2[c]     = ($urandom % 300) == 0;
                    t_cold[c]     = ($urandom % 200) == 0;
                    t_warm[c]     = ($urandom % 20) == 0;
                    t_hot[c]      = ($urandom % 150) == 0;
                    ctest_fail[c] = ($urandom % 30) == 0;
                    term_req[c]   = ($urandom % 60) == 0;
                end
                run_cycle();
            end
            uvlo = 1'b0; suspend = 1'b0;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule